// File: doc/BRIEF.md
# Dual-Clock FIFO with Write Masking and Read Skipping

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Each side keeps its own pointer, Gray-codes it, and passes it through a two-stage synchronizer into the other clock domain. The pointers are one bit wider than the storage address, which lets each side tell a full buffer from an empty one. Each side raises its own occupancy flags from its local pointer and the synchronized copy of the far pointer.

Either side can move its pointer without touching the data. A write request with the mask input high uses up a slot but leaves the old word in that slot. A later read of that slot returns the word that was stored there on an earlier lap. A read request with the skip input high frees a slot but puts nothing on the output bus. The output register holds its previous value, and the valid strobe stays inactive for that word.

Every word that is really delivered is marked by an active-low valid strobe on the read clock. The strobe is low in exactly the cycle in which the word sits on `q`, so the consumer does not need to track the latency from request to data. All flags and the strobe are active low. Both resets are synchronous and active high, one per clock domain. The address width must be at least 2.

Top module: `dcf_skip_fifo`

## Requirements
- R1: Words accepted by unmasked writes and consumed by unskipped reads appear on `q` in the order they were written.
- R2: A read accepted at a rising `rclk` edge with `rd_skip` low drives the word onto `q` at that same edge, and `dval_n` is 0 in the following cycle only.
- R3: A write accepted with `wr_mask` high advances the write pointer but leaves the addressed slot unchanged, so reading that slot later returns the word stored there on an earlier lap.
- R4: A read accepted with `rd_skip` high advances the read pointer, keeps `dval_n` at 1 and leaves `q` unchanged. Whenever `dval_n` is 1, `q` holds its previous value.
- R5: `full_n` is 0 once all 2^AW slots are occupied, as counted by the write side. While `full_n` is 0, `wr_req` is ignored: no slot is taken and no data is stored.
- R6: `empty_n` is 0 when no slot is occupied, as counted by the read side. While `empty_n` is 0, `rd_req` is ignored: no pointer moves and `dval_n` stays 1.
- R7: `half_n` is 0 whenever the write-side occupancy is at least half of the storage slots, and 1 below that.
- R8: After reset, `empty_n`=0, `full_n`=1, `half_n`=1, `dval_n`=1 and `q`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_req | input | 1 | Write request (active high) |
| wr_mask | input | 1 | 1: advance the write pointer without storing |
| wr_data | input | DW | Write data |
| full_n | output | 1 | 0 when all slots are occupied (write domain) |
| half_n | output | 1 | 0 when occupancy is at least half (write domain) |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_req | input | 1 | Read request (active high) |
| rd_skip | input | 1 | 1: advance the read pointer without output |
| q | output | DW | Read data, held between delivered words |
| dval_n | output | 1 | 0 in the cycle a delivered word is on `q` |
| empty_n | output | 1 | 0 when no slot is occupied (read domain) |

## Verification
A wrong pointer shows up as a word that is out of order, repeated or missing on `q`. It appears on the first strobe that follows the fault, which is one read-clock cycle after the faulty request. A mask or skip that goes wrong shows either as a fresh word where an earlier-lap word was expected, or as a strobe and a `q` change where the bus should have stayed quiet. A wrong synchronized pointer or occupancy count shows as a flag at the wrong level, either in the cycle after the 8th or 16th write, or when the buffer should settle empty a few read cycles after a drain.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DEF_DW = 36;
    localparam int DEF_AW = 4;

    typedef enum logic [1:0] {
        WA_IDLE,
        WA_BLOCK,
        WA_MASK,
        WA_STORE
    } wr_act_e;

    typedef enum logic [1:0] {
        RA_IDLE,
        RA_BLOCK,
        RA_SKIP,
        RA_LOAD
    } rd_act_e;

    function automatic wr_act_e wr_decide(input logic req, input logic room, input logic mask);
        if (!req)  return WA_IDLE;
        if (!room) return WA_BLOCK;
        return mask ? WA_MASK : WA_STORE;
    endfunction

    function automatic rd_act_e rd_decide(input logic req, input logic avail, input logic skip);
        if (!req)   return RA_IDLE;
        if (!avail) return RA_BLOCK;
        return skip ? RA_SKIP : RA_LOAD;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] slots [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          wr_mask,
    input  logic [AW:0]   rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          half_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    wr_act_e       act;
    logic          adv;
    logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_sync, level_nx;
    logic          full_match;

    always_comb begin
        act = wr_decide(wr_req, full_n, wr_mask);
        adv = (act == WA_STORE) || (act == WA_MASK);
    end

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_sync[i] = ^(rgray_sync >> i);
        end
    end

    always_comb begin
        wbin_nx    = wbin + PW'(adv);
        wgray_nx   = wbin_nx ^ (wbin_nx >> 1);
        level_nx   = wbin_nx - rbin_sync;
        full_match = (wgray_nx == {~rgray_sync[PW-1 -: 2], rgray_sync[PW-3:0]});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
            half_n <= 1'b1;
        end else begin
            wbin   <= wbin_nx;
            wgray  <= wgray_nx;
            full_n <= !full_match;
            half_n <= !(level_nx >= PW'(HALF));
        end
    end

    assign mem_we    = (act == WA_STORE);
    assign mem_waddr = wbin[AW-1:0];

    // R5: a request refused because the buffer is full leaves the pointer where it was
    a_r5_blocked_write_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !full_n) |=> (wgray == $past(wgray)));

    // R7: a full buffer is also at least half full
    a_r7_full_implies_half: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !half_n);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          rd_skip,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic          dval_n,
    output logic [DW-1:0] q
);
    localparam int PW = AW + 1;

    rd_act_e       act;
    logic          adv;
    logic [PW-1:0] rbin, rbin_nx, rgray_nx;

    always_comb begin
        act      = rd_decide(rd_req, empty_n, rd_skip);
        adv      = (act == RA_SKIP) || (act == RA_LOAD);
        rbin_nx  = rbin + PW'(adv);
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_n <= 1'b0;
            dval_n  <= 1'b1;
            q       <= '0;
        end else begin
            rbin    <= rbin_nx;
            rgray   <= rgray_nx;
            empty_n <= (rgray_nx != wgray_sync);
            dval_n  <= (act != RA_LOAD);
            if (act == RA_LOAD) q <= mem_rdata;
        end
    end

    assign mem_raddr = rbin[AW-1:0];

    // R2: an accepted plain read is strobed in the next cycle
    a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty_n && !rd_skip) |=> !dval_n);

    // R4: a skipped read leaves the bus quiet
    a_r4_skip_quiet: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_skip) |=> (dval_n && $stable(q)));

    // R6: a read refused on empty produces no strobe
    a_r6_empty_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !empty_n) |=> dval_n);
endmodule

// File: rtl/dcf_skip_fifo.sv
module dcf_skip_fifo
    import dcf_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int AW = DEF_AW
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_req,
    input  logic          wr_mask,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    output logic          half_n,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_req,
    input  logic          rd_skip,
    output logic [DW-1:0] q,
    output logic          dval_n,
    output logic          empty_n
);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;

    dcf_wr_ctrl #(.AW(AW)) u_wr (
        .clk        (wclk),
        .rst        (wrst),
        .wr_req     (wr_req),
        .wr_mask    (wr_mask),
        .rgray_sync (rgray_sync),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wgray      (wgray),
        .full_n     (full_n),
        .half_n     (half_n)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk (wclk),
        .rst (wrst),
        .d   (rgray),
        .q   (rgray_sync)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk (rclk),
        .rst (rrst),
        .d   (wgray),
        .q   (wgray_sync)
    );

    dcf_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcf_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .clk        (rclk),
        .rst        (rrst),
        .rd_req     (rd_req),
        .rd_skip    (rd_skip),
        .wgray_sync (wgray_sync),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rgray      (rgray),
        .empty_n    (empty_n),
        .dval_n     (dval_n),
        .q          (q)
    );

    // R3: a masked request never writes the storage array
    a_r3_mask_never_stores: assert property (@(posedge wclk) disable iff (wrst)
        (wr_req && wr_mask) |-> !mem_we);
endmodule

// File: tb/sim_dcf_skip_fifo.sv
module sim_dcf_skip_fifo;
    localparam int DW    = 36;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst = 1'b1, rrst = 1'b1;
    logic          wr_req = 1'b0, wr_mask = 1'b0, rd_req = 1'b0, rd_skip = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] q;
    logic          full_n, half_n, dval_n, empty_n;

    always #4 wclk = ~wclk;     // 125 MHz
    always #5.5 rclk = ~rclk;

    dcf_skip_fifo #(.DW(DW), .AW(AW)) u0 (
        .wclk(wclk), .wrst(wrst), .wr_req(wr_req), .wr_mask(wr_mask), .wr_data(wr_data),
        .full_n(full_n), .half_n(half_n),
        .rclk(rclk), .rrst(rrst), .rd_req(rd_req), .rd_skip(rd_skip),
        .q(q), .dval_n(dval_n), .empty_n(empty_n)
    );

    int            nchk = 0, nbad = 0;
    bit            finished = 1'b0, mon_on = 1'b0;
    logic [DW-1:0] mdl [DEPTH];
    int            wp = 0;
    logic [DW-1:0] wq[$];
    logic [DW-1:0] eq[$];
    logic [DW-1:0] q_last = '0;
    logic [DW-1:0] exp_w;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write driver: feeds the model of the array and the slot-order queue
    task automatic wr_push(input logic [DW-1:0] d, input logic m);
        @(negedge wclk);
        while (!full_n) @(negedge wclk);
        wr_req = 1'b1; wr_data = d; wr_mask = m;
        if (!m) mdl[wp] = d;
        wq.push_back(mdl[wp]);
        wp = (wp + 1) % DEPTH;
        @(posedge wclk); #1;
        wr_req = 1'b0; wr_mask = 1'b0;
    endtask

    // read driver: pops the slot queue, forwards delivered words to the scoreboard
    task automatic rd_pop(input logic s);
        logic [DW-1:0] v;
        @(negedge rclk);
        while (!empty_n) @(negedge rclk);
        rd_req = 1'b1; rd_skip = s;
        if (wq.size() == 0) begin
            chk(1'b0, "R6 read accepted with nothing written", 1, 0);
        end else begin
            v = wq.pop_front();
            if (!s) eq.push_back(v);
        end
        @(posedge rclk); #1;
        rd_req = 1'b0; rd_skip = 1'b0;
        @(negedge rclk);
        if (s) chk(dval_n == 1'b1, "R4 skipped read strobe", dval_n, 1);
        else   chk(dval_n == 1'b0, "R2 delivered read strobe", dval_n, 0);
    endtask

    // monitor: compares delivered words with the scoreboard, checks q holds otherwise
    always @(negedge rclk) begin
        if (mon_on) begin
            if (!dval_n) begin
                if (eq.size() == 0) begin
                    chk(1'b0, "R1/R3 unexpected word", q, 0);
                end else begin
                    exp_w = eq.pop_front();
                    chk(q == exp_w, "R1/R3 word order and content", q, exp_w);
                end
            end else begin
                chk(q == q_last, "R4 q holds without strobe", q, q_last);
            end
            q_last = q;
        end
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!finished) begin
            chk(1'b0, "R1 watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (6) @(negedge rclk);
        @(negedge wclk); wrst = 1'b0;
        @(negedge rclk); rrst = 1'b0;
        mon_on = 1'b1;
        @(negedge rclk);
        // R8 reset state
        chk(empty_n == 1'b0, "R8 empty_n", empty_n, 0);
        chk(dval_n == 1'b1, "R8 dval_n", dval_n, 1);
        chk(q == '0, "R8 q", q, 0);
        chk(full_n == 1'b1, "R8 full_n", full_n, 1);
        chk(half_n == 1'b1, "R8 half_n", half_n, 1);

        // fill, watching the half and full thresholds
        for (int i = 0; i < DEPTH; i++) begin
            wr_push(36'hA0000_0000 + 36'(i), 1'b0);
            @(negedge wclk);
            if (i == DEPTH/2 - 2) chk(half_n == 1'b1, "R7 below half", half_n, 1);
            if (i == DEPTH/2 - 1) chk(half_n == 1'b0, "R7 at half", half_n, 0);
            if (i == DEPTH - 2)   chk(full_n == 1'b1, "R5 one slot left", full_n, 1);
            if (i == DEPTH - 1)   chk(full_n == 1'b0, "R5 full", full_n, 0);
        end

        // writes refused while full
        @(negedge wclk);
        wr_req = 1'b1; wr_data = 36'hBAD_BAD_BAD;
        repeat (3) @(negedge wclk);
        chk(full_n == 1'b0, "R5 stays full under refused writes", full_n, 0);
        wr_req = 1'b0;

        // drain with two skipped words
        for (int i = 0; i < DEPTH; i++) rd_pop((i == 2) || (i == 9));
        chk(empty_n == 1'b0, "R6 empty after drain", empty_n, 0);
        repeat (10) @(negedge rclk);
        chk(empty_n == 1'b0, "R5 refused writes stored nothing", empty_n, 0);
        chk(eq.size() == 0, "R1 all delivered", eq.size(), 0);

        // reads refused while empty
        @(negedge rclk); rd_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge rclk);
            chk(dval_n == 1'b1, "R6 no strobe on empty", dval_n, 1);
        end
        rd_req = 1'b0;
        repeat (4) @(negedge wclk);
        chk(full_n == 1'b1, "R5 full released", full_n, 1);
        chk(half_n == 1'b1, "R7 half released", half_n, 1);

        // one word through: refused reads moved nothing
        wr_push(36'h1234_5678_9, 1'b0);
        rd_pop(1'b0);

        // masked lap: masked slots keep earlier-lap words
        for (int i = 0; i < 8; i++) wr_push(36'hC0000_0000 + 36'(i), (i == 1) || (i == 4));
        for (int i = 0; i < 8; i++) rd_pop(1'b0);

        // concurrent mixed traffic
        fork
            begin
                for (int i = 0; i < 300; i++) begin
                    wr_push(36'hD0000_0000 + 36'(i), ($urandom_range(3) == 0));
                    if ($urandom_range(4) == 0) repeat ($urandom_range(6)) @(negedge wclk);
                end
            end
            begin
                for (int i = 0; i < 300; i++) begin
                    rd_pop($urandom_range(3) == 0);
                    if ($urandom_range(4) == 0) repeat ($urandom_range(6)) @(negedge rclk);
                end
            end
        join

        repeat (20) @(negedge rclk);
        chk(empty_n == 1'b0, "R6 empty after traffic", empty_n, 0);
        chk(eq.size() == 0, "R1 scoreboard drained", eq.size(), 0);
        chk(wq.size() == 0, "R1 slot queue drained", wq.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule